// File: doc/BRIEF.md
# Register Scan-Out Word Packer

This block turns one 36-position machine register (32 data bits and 4 byte-parity bits) into storage words during a scan-out or logout. A register that wide needs two storage words. The first word comes from the normal pass and holds data bits 0-27 followed by the four parity bits. The second word comes from the fold pass and holds only data bits 28-31, in word positions 24-27.

A 6-bit op code chooses the source register and the pass. Bit 0x20 of the op code selects the fold pass. Each start pulse yields one storage word. Fresh odd parity is computed for each byte of the outgoing word, including the register parity bits already packed into it, and is appended in storage positions 32-35. The storage address begins at a base value and advances by one fullword after every write. An op code the block does not know produces no write and raises a one-cycle flag instead.

Bit positions follow the storage convention: position 0 is the most significant bit. Storage position p of `wr_data` is vector bit [35-p]. On a source register, data bit d is vector bit [35-d], and the parity bit of byte k is vector bit [3-k].

Top module: `scan_fold_unit`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `wr_en` and `illegal_op` are 0 and `wr_addr` equals BASE_ADDR (default 0x000200).
- R2: In the normal pass, storage positions 0-27 hold source data bits 0-27, and positions 28-31 hold source parity bits 0-3 in byte order.
- R3: In the fold pass, storage positions 24-27 hold source data bits 28-31, and every other position from 0 to 31 is 0.
- R4: Op code 0x11 selects source H, 0x15 selects M, 0x16 selects R and 0x17 selects L. Adding 0x20 (0x31, 0x35, 0x36, 0x37) selects the fold pass of the same source.
- R5: Storage positions 32-35 hold odd parity for bytes 0-3 of positions 0-31, one bit per byte, so that each byte together with its parity bit has an odd number of ones.
- R6: A start with a legal op code in cycle n gives `wr_en`=1 with that word in cycle n+1. Start held for k cycles gives k writes.
- R7: The first write uses BASE_ADDR. Every later write uses the previous write address plus 4.
- R8: A start with any other op code gives no write in the next cycle, raises `illegal_op` for that one cycle, and leaves the address of the next write unchanged.
- R9: In a cycle with no start, the next cycle has `wr_en`=0 and `illegal_op`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request one storage word this cycle |
| op | input | 6 | Source and pass select |
| src_h | input | 36 | Source register H |
| src_m | input | 36 | Source register M |
| src_r | input | 36 | Source register R |
| src_l | input | 36 | Source register L |
| wr_en | output | 1 | Storage write strobe |
| wr_data | output | 36 | Storage word: 32 scan bits plus 4 generated parity bits |
| wr_addr | output | 24 | Storage byte address of this write |
| illegal_op | output | 1 | One-cycle flag for an unknown op code |

## Verification
The assertions check several properties on every cycle. Each start leads to exactly one outcome, a write or a flag. An idle cycle leads to neither. Every written word has odd parity in each byte. A fold word has zeros outside positions 24-27. The next address stays one fullword ahead of the last write, and an illegal op leaves that address unchanged. Only the bench scenarios can show that each op code selects the right register, that the normal pass places data and parity bits in the right positions, and that the address sequence is correct across back-to-back and interleaved requests.

// File: rtl/scan_fold_pkg.sv
package scan_fold_pkg;

    typedef enum logic [1:0] {
        SRC_H = 2'd0,
        SRC_M = 2'd1,
        SRC_R = 2'd2,
        SRC_L = 2'd3
    } src_sel_e;

    typedef struct packed {
        logic     legal;
        logic     fold;
        src_sel_e sel;
    } op_dec_t;

endpackage

// File: rtl/scan_op_decode.sv
module scan_op_decode
    import scan_fold_pkg::*;
#(
    parameter int OP_W     = 6,
    parameter int FOLD_BIT = 5
) (
    input  logic [OP_W-1:0] op,
    output op_dec_t         dec
);
    localparam int LOW_W = FOLD_BIT;

    logic [LOW_W-1:0] base_code;

    always_comb begin
        base_code = op[LOW_W-1:0];
        dec.fold  = op[FOLD_BIT];
        dec.legal = 1'b1;
        dec.sel   = SRC_H;
        unique case (base_code)
            LOW_W'(8'h11): dec.sel = SRC_H;
            LOW_W'(8'h15): dec.sel = SRC_M;
            LOW_W'(8'h16): dec.sel = SRC_R;
            LOW_W'(8'h17): dec.sel = SRC_L;
            default:       dec.legal = 1'b0;
        endcase
    end
endmodule

// File: rtl/scan_word_pack.sv
module scan_word_pack #(
    parameter int DATA_W = 32,
    parameter int PAR_W  = 4
) (
    input  logic [DATA_W+PAR_W-1:0] src,
    input  logic                    fold,
    output logic [DATA_W-1:0]       word
);
    localparam int SRC_W  = DATA_W + PAR_W;
    localparam int KEEP_W = DATA_W - PAR_W;
    localparam int TAIL_W = DATA_W - KEEP_W;

    logic [DATA_W-1:0] normal_w;
    logic [DATA_W-1:0] fold_w;

    always_comb begin
        normal_w = {src[SRC_W-1 -: KEEP_W], src[PAR_W-1:0]};
        fold_w   = '0;
        fold_w[PAR_W +: TAIL_W] = src[PAR_W +: TAIL_W];
        word = fold ? fold_w : normal_w;
    end
endmodule

// File: rtl/byte_parity_gen.sv
module byte_parity_gen #(
    parameter int DATA_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic [DATA_W-1:0]        data,
    output logic [DATA_W/BYTE_W-1:0] par
);
    localparam int NB = DATA_W / BYTE_W;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign par[NB-1-g] = ~(^data[DATA_W-1-g*BYTE_W -: BYTE_W]);
    end
endmodule

// File: rtl/scan_fold_unit.sv
module scan_fold_unit
    import scan_fold_pkg::*;
#(
    parameter int          DATA_W    = 32,
    parameter int          PAR_W     = 4,
    parameter int          OP_W      = 6,
    parameter int          ADDR_W    = 24,
    parameter logic [23:0] BASE_ADDR = 24'h000200,
    parameter int          ADDR_STEP = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [OP_W-1:0]         op,
    input  logic [DATA_W+PAR_W-1:0] src_h,
    input  logic [DATA_W+PAR_W-1:0] src_m,
    input  logic [DATA_W+PAR_W-1:0] src_r,
    input  logic [DATA_W+PAR_W-1:0] src_l,
    output logic                    wr_en,
    output logic [DATA_W+PAR_W-1:0] wr_data,
    output logic [ADDR_W-1:0]       wr_addr,
    output logic                    illegal_op
);
    localparam int SRC_W   = DATA_W + PAR_W;
    localparam int NB      = DATA_W / 8;
    localparam int TAIL_W  = PAR_W;
    localparam logic [SRC_W-1:0] FOLD_MASK = {{(DATA_W-PAR_W-TAIL_W){1'b0}}, {TAIL_W{1'b1}},
                                              {PAR_W{1'b0}}, {PAR_W{1'b0}}};
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(ADDR_STEP);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(BASE_ADDR);

    typedef struct packed {
        logic              wr_en;
        logic              illegal;
        logic              fold;
        logic [SRC_W-1:0]  data;
        logic [ADDR_W-1:0] wr_addr;
        logic [ADDR_W-1:0] next_addr;
    } state_t;

    state_t st_d, st_q;

    op_dec_t           dec;
    logic [SRC_W-1:0]  src_sel;
    logic [DATA_W-1:0] packed_w;
    logic [NB-1:0]     gen_par;

    scan_op_decode #(.OP_W(OP_W), .FOLD_BIT(OP_W-1)) u_dec (
        .op  (op),
        .dec (dec)
    );

    always_comb begin
        unique case (dec.sel)
            SRC_H:   src_sel = src_h;
            SRC_M:   src_sel = src_m;
            SRC_R:   src_sel = src_r;
            default: src_sel = src_l;
        endcase
    end

    scan_word_pack #(.DATA_W(DATA_W), .PAR_W(PAR_W)) u_pack (
        .src  (src_sel),
        .fold (dec.fold),
        .word (packed_w)
    );

    byte_parity_gen #(.DATA_W(DATA_W), .BYTE_W(8)) u_par (
        .data (packed_w),
        .par  (gen_par)
    );

    always_comb begin
        st_d         = st_q;
        st_d.wr_en   = 1'b0;
        st_d.illegal = 1'b0;
        if (start) begin
            if (dec.legal) begin
                st_d.wr_en     = 1'b1;
                st_d.fold      = dec.fold;
                st_d.data      = {packed_w, gen_par};
                st_d.wr_addr   = st_q.next_addr;
                st_d.next_addr = st_q.next_addr + STEP;
            end else begin
                st_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.wr_en     <= 1'b0;
            st_q.illegal   <= 1'b0;
            st_q.fold      <= 1'b0;
            st_q.data      <= '0;
            st_q.wr_addr   <= BASE;
            st_q.next_addr <= BASE;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_en      = st_q.wr_en;
    assign wr_data    = st_q.data;
    assign wr_addr    = st_q.wr_addr;
    assign illegal_op = st_q.illegal;

    a_r6_write_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dec.legal) |=> wr_en);

    a_r8_illegal_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !dec.legal) |=> (illegal_op && !wr_en && $stable(st_q.next_addr)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (!wr_en && !illegal_op));

    a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st_q.next_addr == wr_addr + STEP));

    a_r3_fold_zeros: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && st_q.fold) |-> ((wr_data[SRC_W-1:PAR_W] & ~FOLD_MASK[SRC_W-1:PAR_W]) == '0));

    for (genvar b = 0; b < NB; b++) begin : g_par_chk
        a_r5_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |-> ($countones({wr_data[SRC_W-1-b*8 -: 8], wr_data[NB-1-b]}) % 2 == 1));
    end
endmodule

// File: tb/scan_fold_unit_bench.sv
module scan_fold_unit_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [23:0] BASE = 24'h000200;

    typedef struct packed {
        logic [5:0] op;
        logic [1:0] idx;
        logic       fold;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{op: 6'h11, idx: 2'd0, fold: 1'b0},
        '{op: 6'h31, idx: 2'd0, fold: 1'b1},
        '{op: 6'h15, idx: 2'd1, fold: 1'b0},
        '{op: 6'h35, idx: 2'd1, fold: 1'b1},
        '{op: 6'h16, idx: 2'd2, fold: 1'b0},
        '{op: 6'h36, idx: 2'd2, fold: 1'b1},
        '{op: 6'h17, idx: 2'd3, fold: 1'b0},
        '{op: 6'h37, idx: 2'd3, fold: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [5:0]  op = '0;
    logic [35:0] src [4];
    logic        wr_en;
    logic [35:0] wr_data;
    logic [23:0] wr_addr;
    logic        illegal_op;

    int total = 0;
    int bad = 0;
    logic [23:0] exp_addr;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scan_fold_unit u_scan_fold_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .src_h(src[0]), .src_m(src[1]), .src_r(src[2]), .src_l(src[3]),
        .wr_en(wr_en), .wr_data(wr_data), .wr_addr(wr_addr), .illegal_op(illegal_op)
    );

    function automatic logic [35:0] model(input logic [35:0] s, input logic f);
        logic [31:0] w;
        logic [3:0]  p;
        w = '0;
        for (int pos = 0; pos < 32; pos++) begin
            if (!f) begin
                if (pos < 28) w[31-pos] = s[35-pos];
                else          w[31-pos] = s[3-(pos-28)];
            end else if (pos >= 24 && pos < 28) begin
                w[31-pos] = s[35-(pos+4)];
            end
        end
        for (int b = 0; b < 4; b++) p[3-b] = ~(^w[31-8*b -: 8]);
        return {w, p};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic fire(input logic [5:0] code);
        @(negedge clk);
        op = code;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        src[0] = 36'h9ABCDEF12;
        src[1] = 36'h123456789;
        src[2] = 36'hFFFFFFFFF;
        src[3] = 36'h80000000F;
        exp_addr = BASE;

        repeat (3) @(negedge clk);
        chk("R1 wr_en in reset", {63'd0, wr_en}, 64'd0);
        chk("R1 illegal in reset", {63'd0, illegal_op}, 64'd0);
        chk("R1 addr in reset", {40'd0, wr_addr}, {40'd0, BASE});
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 wr_en after reset", {63'd0, wr_en}, 64'd0);
        chk("R9 idle no illegal", {63'd0, illegal_op}, 64'd0);

        // R2 R3 R4 R5 R6 R7: table walk
        for (int i = 0; i < 8; i++) begin
            fire(VECS[i].op);
            chk("R6 write strobe", {63'd0, wr_en}, 64'd1);
            chk(VECS[i].fold ? "R3 R4 R5 fold word" : "R2 R4 R5 normal word",
                {28'd0, wr_data}, {28'd0, model(src[VECS[i].idx], VECS[i].fold)});
            chk("R7 address", {40'd0, wr_addr}, {40'd0, exp_addr});
            exp_addr = exp_addr + 24'd4;
            @(negedge clk);
            chk("R9 single write", {63'd0, wr_en}, 64'd0);
        end

        // R8: unknown op codes
        for (int j = 0; j < 4; j++) begin
            logic [5:0] bad_op;
            bad_op = (j == 0) ? 6'h00 : (j == 1) ? 6'h20 : (j == 2) ? 6'h3F : 6'h12;
            fire(bad_op);
            chk("R8 no write", {63'd0, wr_en}, 64'd0);
            chk("R8 illegal flag", {63'd0, illegal_op}, 64'd1);
            @(negedge clk);
            chk("R8 flag one cycle", {63'd0, illegal_op}, 64'd0);
        end
        fire(6'h17);
        chk("R8 addr unchanged after illegal", {40'd0, wr_addr}, {40'd0, exp_addr});
        exp_addr = exp_addr + 24'd4;

        // R6 R7: start held two cycles, new source values
        src[0] = 36'h00FF00FF0;
        src[2] = 36'h5A5A5A5A5;
        @(negedge clk);
        op = 6'h11;
        start = 1'b1;
        @(negedge clk);
        chk("R6 back-to-back first", {63'd0, wr_en}, 64'd1);
        chk("R2 back-to-back data", {28'd0, wr_data}, {28'd0, model(src[0], 1'b0)});
        chk("R7 back-to-back addr0", {40'd0, wr_addr}, {40'd0, exp_addr});
        exp_addr = exp_addr + 24'd4;
        op = 6'h36;
        @(negedge clk);
        start = 1'b0;
        chk("R6 back-to-back second", {63'd0, wr_en}, 64'd1);
        chk("R3 back-to-back fold", {28'd0, wr_data}, {28'd0, model(src[2], 1'b1)});
        chk("R7 back-to-back addr1", {40'd0, wr_addr}, {40'd0, exp_addr});
        exp_addr = exp_addr + 24'd4;

        // R9: op changes with no start
        op = 6'h15;
        @(negedge clk);
        @(negedge clk);
        chk("R9 no start no write", {63'd0, wr_en}, 64'd0);
        fire(6'h35);
        chk("R7 addr after idle", {40'd0, wr_addr}, {40'd0, exp_addr});

        // R1: reset mid-run restores the base address
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        fire(6'h11);
        chk("R1 addr restarts at base", {40'd0, wr_addr}, {40'd0, BASE});

        finish_run();
    end
endmodule